// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast one fan turns. It counts prescaled reference ticks between two consecutive rising edges of the fan's tachometer signal. A larger result means a slower fan. The tachometer line is asynchronous to the block's clock, so it first passes through a synchronizer and an edge detector. The reference time base is a one-cycle enable (`ref_en`). A 2-bit divide setting slows it by 1, 2, 4 or 8, which sets the speed range: a slow fan still gives a mid-scale result instead of running off the top.

The count register saturates at all-ones. That value means a stalled or very slow fan. It is forced as soon as the running count reaches full scale, even if no tachometer edge has arrived. A measurement sequencer pulses `start` to begin a fresh measurement. Each latched result comes with a one-cycle `done` strobe. `over_limit` reports that the latched count is strictly greater than a programmed limit, which means the fan is slower than allowed. An elaboration option fixes the divisor for a channel whose speed range cannot be programmed. The nominal operating point sits near a count of 153.

Top module: `fan_tach_counter`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, `count_q` is 0, and `done` and `over_limit` are 0.
- R2: A rising edge of `tach_in` that is first sampled at clock edge k is acted on at clock edge k+2. Its `done` and new `count_q` are visible after edge k+2 and not before.
- R3: On each rising tachometer edge that follows an earlier one since the last `start`, `count_q` takes the number of prescaled ticks seen between the two edges, and `done` is high for that one cycle. `count_q` changes only in cycles where `done` is high. With `ref_en` held high, divisor d and edge spacing P cycles, the result is min(255, floor((P-1)/d)).
- R4: `div_sel` encodes the divisor as 0=1, 1=2, 2=4, 3=8. The prescaler restarts from zero on every acted-on rising edge and on `start`.
- R5: When the running count reaches 255 before the next rising edge, `count_q` becomes 255 with a single `done` pulse. It stays 255 until a later edge latches a new period.
- R6: `start` clears the running count and disarms the channel. The first rising edge after `start` latches nothing and raises no `done`, and `count_q` keeps its earlier value. `start` takes priority over a simultaneous edge.
- R7: The prescaler and the running count advance only on cycles where `ref_en` is high.
- R8: `over_limit` is 1 exactly when `count_q` is strictly greater than `limit`. A count equal to the limit gives 0.
- R9: With `FIXED_DIV` set, the channel divides by the `FIXED_SEL` setting (default 1, divide by 2) and ignores `div_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference tick enable, one cycle per tick |
| tach_in | input | 1 | Asynchronous tachometer input |
| start | input | 1 | Restart pulse from the measurement sequencer |
| div_sel | input | 2 | Divisor setting (0=1, 1=2, 2=4, 3=8) |
| limit | input | 8 | Speed limit as a maximum count |
| count_q | output | 8 | Latched period count |
| done | output | 1 | One-cycle strobe on each latched count |
| over_limit | output | 1 | Latched count is greater than the limit |

## Verification
The bench builds two copies of the block side by side with an 8-bit count and a 2-bit divide setting. One copy has a programmable divisor and the other has `FIXED_DIV` set with the default divide-by-2. Both are fed the same tachometer waveform and `div_sel`, so every change to `div_sel` tests that the fixed copy ignores it. With an 8-bit count and at most divide-by-8, full-scale saturation is reached within a few hundred to about two thousand cycles. The stall case, the restart after saturation and all four divider settings therefore fit in one short run.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

   // Prescale settings; the divisor is two to the power of the code.
   typedef enum logic [1:0] {
      DIV_BY1 = 2'd0,
      DIV_BY2 = 2'd1,
      DIV_BY4 = 2'd2,
      DIV_BY8 = 2'd3
   } tach_div_e;

   localparam int unsigned TACH_SYNC_DEPTH = 2;

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tach_in,
   output logic rise
);

   // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-cycle history
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh <= '0;
      end else begin
         sh <= {sh[STAGES-1:0], tach_in};
      end
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   // Largest divisor is 2**(2**SEL_W - 1)
   localparam int unsigned PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] mask;

   assign mask = ~({PRE_W{1'b1}} << sel);
   assign tick = ref_en && ((pre & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre <= '0;
      end else if (restart) begin
         pre <= '0;
      end else if (ref_en) begin
         pre <= pre + 1'b1;
      end
   end

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rise,
   input  logic             tick,
   output logic [CNT_W-1:0] count_q,
   output logic             done
);

   localparam logic [CNT_W-1:0] FULL      = '1;
   localparam logic [CNT_W-1:0] NEAR_FULL = {{(CNT_W-1){1'b1}}, 1'b0};

   logic [CNT_W-1:0] run_cnt;
   logic             armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
         armed   <= 1'b0;
         count_q <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            run_cnt <= '0;
            armed   <= 1'b0;
         end else if (rise) begin
            if (armed) begin
               count_q <= run_cnt;
               done    <= 1'b1;
            end
            run_cnt <= '0;
            armed   <= 1'b1;
         end else if (tick && (run_cnt != FULL)) begin
            run_cnt <= run_cnt + 1'b1;
            if (run_cnt == NEAR_FULL) begin
               count_q <= FULL;
               done    <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/fan_tach_counter.sv
module fan_tach_counter #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned SYNC_STAGES = fan_tach_pkg::TACH_SYNC_DEPTH,
   parameter bit          FIXED_DIV   = 1'b0,
   parameter int unsigned FIXED_SEL   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic             tach_in,
   input  logic             start,
   input  logic [SEL_W-1:0] div_sel,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count_q,
   output logic             done,
   output logic             over_limit
);

   // Elaboration-time parameter checks
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("fan_tach_counter: CNT_W must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel_w
      $error("fan_tach_counter: SEL_W must be 1 to 3");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fan_tach_counter: SYNC_STAGES must be at least 2");
   end
   if (FIXED_SEL >= (1 << SEL_W)) begin : g_bad_fixed
      $error("fan_tach_counter: FIXED_SEL out of range");
   end

   logic [SEL_W-1:0] eff_sel;
   logic             rise;
   logic             tick;

   if (FIXED_DIV) begin : g_fixed_div
      assign eff_sel = SEL_W'(FIXED_SEL);
   end else begin : g_prog_div
      assign eff_sel = div_sel;
   end

   tach_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tach_in (tach_in),
      .rise    (rise)
   );

   tach_prescaler #(
      .SEL_W (SEL_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_en  (ref_en),
      .restart (start | rise),
      .sel     (eff_sel),
      .tick    (tick)
   );

   tach_period_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rise    (rise),
      .tick    (tick),
      .count_q (count_q),
      .done    (done)
   );

   assign over_limit = (count_q > limit);

endmodule

// File: rtl/fan_tach_counter_chk.sv
module fan_tach_counter_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tach_in,
   input logic             start,
   input logic [CNT_W-1:0] limit,
   input logic [CNT_W-1:0] count_q,
   input logic             done,
   input logic             over_limit
);

   localparam logic [CNT_W-1:0] FULL = '1;

   // R2: a non-saturation result follows a low-to-high input three and four samples back
   p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && count_q != FULL) |-> ($past(tach_in, 3) && !$past(tach_in, 4)));

   // R3: the result register moves only together with the strobe
   p_count_moves_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count_q) |-> done);

   // R6: a restart never produces a result in the following cycle
   p_start_blocks_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

   // R8: a saturated count exceeds any limit below full scale
   p_full_flags_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == FULL && limit != FULL) |-> over_limit);

   // R8: a zero count is never over a limit
   p_zero_never_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0) |-> !over_limit);

endmodule

bind fan_tach_counter fan_tach_counter_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tach_in    (tach_in),
   .start      (start),
   .limit      (limit),
   .count_q    (count_q),
   .done       (done),
   .over_limit (over_limit)
);

// File: tb/test_fan_tach_counter.sv
module test_fan_tach_counter;

   localparam int CLK_P = 10;

   logic       clk     = 1'b0;
   logic       rst_n   = 1'b0;
   logic       ref_en  = 1'b1;
   logic       tach    = 1'b0;
   logic       start   = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic [7:0] limit   = 8'd200;
   logic       gate    = 1'b0;

   logic [7:0] cq0, cq1;
   logic       dn0, dn1, ov0, ov1;

   int checks = 0;
   int errors = 0;
   int dn_cnt = 0;

   always #(CLK_P/2) clk = ~clk;

   fan_tach_counter i_fan_tach_counter (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tach_in(tach), .start(start),
      .div_sel(div_sel), .limit(limit), .count_q(cq0), .done(dn0), .over_limit(ov0)
   );

   fan_tach_counter #(.FIXED_DIV(1'b1), .FIXED_SEL(1)) i_fan_tach_counter_fixed (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tach_in(tach), .start(start),
      .div_sel(div_sel), .limit(limit), .count_q(cq1), .done(dn1), .over_limit(ov1)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Behavioural reference: index 0 programmable, index 1 fixed divide-by-2
   int m_cnt[2], m_pre[2], m_arm[2], m_cq[2], m_dn[2];
   bit hq[$] = '{1'b0, 1'b0, 1'b0};

   always @(posedge clk) begin
      bit rise;
      bit tk;
      int d;
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_pre[i] = 0; m_arm[i] = 0; m_cq[i] = 0; m_dn[i] = 0;
         end
         hq = '{1'b0, 1'b0, 1'b0};
      end else begin
         rise = hq[1] && !hq[0];
         for (int i = 0; i < 2; i++) begin
            d  = (i == 0) ? (1 << div_sel) : 2;
            tk = ref_en && ((m_pre[i] % d) == d - 1);
            m_dn[i] = 0;
            if (start) begin
               m_cnt[i] = 0; m_arm[i] = 0; m_pre[i] = 0;
            end else if (rise) begin
               if (m_arm[i] != 0) begin
                  m_cq[i] = m_cnt[i]; m_dn[i] = 1;
               end
               m_cnt[i] = 0; m_arm[i] = 1; m_pre[i] = 0;
            end else begin
               if (ref_en) m_pre[i] = (m_pre[i] + 1) % 8;
               if (tk && m_cnt[i] < 255) begin
                  m_cnt[i]++;
                  if (m_cnt[i] == 255) begin
                     m_cq[i] = 255; m_dn[i] = 1;
                  end
               end
            end
         end
         hq.push_back(tach);
         void'(hq.pop_front());
      end
      #(CLK_P/4);
      chk("R3 count prog", int'(cq0), m_cq[0]);
      chk("R3 done prog", int'(dn0), m_dn[0]);
      chk("R8 flag prog", int'(ov0), (m_cq[0] > int'(limit)) ? 1 : 0);
      chk("R9 count fixed", int'(cq1), m_cq[1]);
      chk("R9 done fixed", int'(dn1), m_dn[1]);
      chk("R8 flag fixed", int'(ov1), (m_cq[1] > int'(limit)) ? 1 : 0);
      if (dn0) dn_cnt++;
   end

   // R7 stimulus: reference enable on alternate cycles
   always @(negedge clk) if (gate) ref_en <= ~ref_en;

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic tach_periods(input int p, input int n);
      for (int k = 0; k < n; k++) begin
         tach = 1'b1;
         repeat (p / 2) @(negedge clk);
         tach = 1'b0;
         repeat (p - p / 2) @(negedge clk);
      end
   endtask

   // Final rise: check R2 latency, then the latched counts (negative = compare to model)
   task automatic final_rise(input string req, input int exp0, input int exp1);
      tach = 1'b1;
      @(posedge clk); #(CLK_P/4);
      chk("R2 no done at edge k", int'(dn0), 0);
      @(posedge clk); #(CLK_P/4);
      chk("R2 no done at edge k+1", int'(dn0), 0);
      @(posedge clk); #(CLK_P/4);
      chk("R2 done at edge k+2", int'(dn0), 1);
      chk(req, int'(cq0), (exp0 >= 0) ? exp0 : m_cq[0]);
      chk("R9 fixed divisor count", int'(cq1), (exp1 >= 0) ? exp1 : m_cq[1]);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset count", int'(cq0), 0);
      chk("R1 reset done", int'(dn0), 0);
      chk("R1 reset flag", int'(ov0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count after release", int'(cq0), 0);
      pulse_start();

      // R4: each divisor code, fixed copy always divides by 2 (R9)
      div_sel = 2'd0; tach_periods(20, 3);  final_rise("R4 div code 0", 19, 9);
      tach = 1'b0;
      div_sel = 2'd1; tach_periods(40, 2);  final_rise("R4 div code 1", 19, 19);
      tach = 1'b0;
      div_sel = 2'd2; tach_periods(100, 2); final_rise("R4 div code 2", 24, 49);
      tach = 1'b0;
      div_sel = 2'd3; tach_periods(200, 2); final_rise("R3 div code 3", 24, 99);

      // R8: boundary of the strict comparison
      limit = 8'd24; @(negedge clk);
      chk("R8 equal to limit", int'(ov0), 0);
      limit = 8'd23; @(negedge clk);
      chk("R8 one above limit", int'(ov0), 1);
      chk("R8 fixed above limit", int'(ov1), 1);
      limit = 8'd200;

      // R5: stalled fan saturates with a single strobe
      tach = 1'b0; div_sel = 2'd0;
      dn_cnt = 0;
      repeat (600) @(negedge clk);
      chk("R5 saturated count", int'(cq0), 255);
      chk("R5 single strobe", dn_cnt, 1);
      chk("R5 fixed saturated", int'(cq1), 255);
      chk("R5 flag at full", int'(ov0), 1);

      // R6: restart, first edge latches nothing
      dn_cnt = 0;
      pulse_start();
      tach = 1'b1;
      repeat (6) @(negedge clk);
      chk("R6 no strobe on first edge", dn_cnt, 0);
      chk("R6 count held", int'(cq0), 255);
      tach = 1'b0;
      repeat (10) @(negedge clk);
      tach_periods(30, 1);
      final_rise("R5 new period after stall", 29, 14);
      tach = 1'b0;

      // R6: start on the same edge a rise is acted on
      tach_periods(30, 1);
      tach = 1'b1;
      @(negedge clk);
      dn_cnt = 0;
      pulse_start();
      repeat (4) @(negedge clk);
      chk("R6 start beats edge", dn_cnt, 0);
      tach = 1'b0;
      repeat (4) @(negedge clk);

      // R7: reference enable on alternate cycles
      gate = 1'b1;
      tach_periods(50, 2);
      final_rise("R7 gated reference", -1, -1);
      chk("R7 gated count below ungated", (int'(cq0) < 49) ? 1 : 0, 1);
      gate = 1'b0;
      ref_en = 1'b1;
      tach = 1'b0;
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule